// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer that steers a multicycle processor datapath in which one memory, one ALU and one register file are shared across the steps of an instruction. Its only data input is the 6-bit opcode field of the instruction register. Its outputs are the full set of datapath control points: the PC write enables, the memory address select, the memory read and write strobes, the instruction register load, the register-file write data select, the PC source select, the ALU operation class, both ALU operand selects, and the register-file write enable and destination select.

The controller is a Moore machine. Every output is a function of the current state alone, and the outputs come straight from flops. Each instruction starts with a fetch step and a decode step. During decode, the branch target is computed speculatively before the opcode is known. After decode, the sequence branches according to the opcode. Loads take five steps, stores and register-register operations take four, and branches and jumps take three. An opcode the controller does not know goes straight back to fetch after decode.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous reset, with rst high at a clock edge, puts the controller in the fetch step. This holds even in the middle of an instruction, and the outputs show the fetch word from the cycle after that edge.
- R2: In the fetch step, these outputs are 1: mem_rd, ir_wr and pc_wr. alu_b_sel is 01 (constant 4). alu_a_sel is 0 (PC), alu_op is 00 (add), addr_sel is 0 (PC) and pc_src is 00 (ALU result). Every other output is 0.
- R3: The cycle after fetch is always decode, for every opcode. In decode, alu_b_sel is 11 (shifted, sign-extended immediate), alu_a_sel is 0 and alu_op is 00, and every write enable and strobe is 0.
- R4: A load (opcode 100011) runs fetch, decode and an address step (alu_a_sel=1, alu_b_sel=10, alu_op=00). It then runs a read step (mem_rd=1, addr_sel=1) and a write-back step (rf_wr=1, wb_sel=1, rf_dst=0), for 5 cycles in all.
- R5: A store (opcode 101011) runs fetch, decode, the same address step, and a write step (mem_wr=1, addr_sel=1), for 4 cycles in all.
- R6: A register-register operation (opcode 000000) runs fetch, decode, an execute step (alu_a_sel=1, alu_b_sel=00, alu_op=10) and a completion step (rf_wr=1, rf_dst=1, wb_sel=0), for 4 cycles in all.
- R7: A branch-if-equal (opcode 000100) runs fetch, decode and a compare step, for 3 cycles in all. The compare step drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_src=01 and pc_wr_cond=1.
- R8: A jump (opcode 000010) runs fetch, decode and a step with pc_src=10 and pc_wr=1, for 3 cycles in all.
- R9: Any other opcode goes from decode straight back to fetch, for 2 cycles in all.
- R10: The opcode is sampled only in decode. Changing it in any later step of the same instruction leaves that instruction's remaining steps unchanged.
- R11: In every state, any output that the state does not name is 0. mem_rd and mem_wr are never 1 together, and neither are pc_wr and pc_wr_cond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU reports zero |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU output register, 1 memory data register |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU operand B: 00 B register, 01 four, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst | output | 1 | Destination field: 0 rt, 1 rd |

## Verification
Two jobs land in the same cycle. In fetch, the instruction register load and the PC+4 write happen together. In decode, the speculative branch-target computation happens in the cycle where the opcode is being sampled. The bench sweeps all 64 opcodes. At every step it compares the whole 16-bit control word with a word built from the requirements, so a fetch missing either its load or its PC write is caught, and so is a decode that already acts on the opcode. After decode, the bench inverts the opcode in each step to show that only the value seen in decode steers the sequence.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_MADDR,
    ST_MREAD,
    ST_MWB,
    ST_MWRITE,
    ST_REXE,
    ST_RWB,
    ST_BRANCH,
    ST_JUMP
  } mc_state_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst;
  } mc_ctrl_t;

  localparam mc_ctrl_t CTRL_FETCH = '{
    pc_wr: 1'b1, pc_wr_cond: 1'b0, addr_sel: 1'b0, mem_rd: 1'b1,
    mem_wr: 1'b0, ir_wr: 1'b1, wb_sel: 1'b0, pc_src: 2'b00,
    alu_op: 2'b00, alu_a_sel: 1'b0, alu_b_sel: 2'b01,
    rf_wr: 1'b0, rf_dst: 1'b0};

endpackage

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
#(
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_LW    = 6'b100011,
  parameter logic [OP_W-1:0] OP_SW    = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_J     = 6'b000010
) (
  input  mc_state_e       state,
  input  logic [OP_W-1:0] opcode,
  input  logic            is_load,
  output mc_state_e       nxt,
  output logic            load_set
);

  always_comb begin
    nxt      = ST_FETCH;
    load_set = (opcode == OP_LW);
    unique case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LW || opcode == OP_SW) nxt = ST_MADDR;
        else if (opcode == OP_RTYPE)            nxt = ST_REXE;
        else if (opcode == OP_BEQ)              nxt = ST_BRANCH;
        else if (opcode == OP_J)                nxt = ST_JUMP;
        else                                    nxt = ST_FETCH;
      end
      ST_MADDR:  nxt = is_load ? ST_MREAD : ST_MWRITE;
      ST_MREAD:  nxt = ST_MWB;
      ST_REXE:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
(
  input  mc_state_e state,
  output mc_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FETCH:  ctrl = CTRL_FETCH;
      ST_DECODE: ctrl.alu_b_sel = 2'b11;
      ST_MADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = 2'b10;
      end
      ST_MREAD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_MWB: begin
        ctrl.rf_wr  = 1'b1;
        ctrl.wb_sel = 1'b1;
      end
      ST_MWRITE: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_op    = 2'b10;
      end
      ST_RWB: begin
        ctrl.rf_wr  = 1'b1;
        ctrl.rf_dst = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_op     = 2'b01;
        ctrl.pc_src     = 2'b01;
        ctrl.pc_wr_cond = 1'b1;
      end
      ST_JUMP: begin
        ctrl.pc_src = 2'b10;
        ctrl.pc_wr  = 1'b1;
      end
      default: ctrl = CTRL_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_LW    = 6'b100011,
  parameter logic [OP_W-1:0] OP_SW    = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_J     = 6'b000010,
  parameter bit              REG_OUT  = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            addr_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            wb_sel,
  output logic [1:0]      pc_src,
  output logic [1:0]      alu_op,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic            rf_wr,
  output logic            rf_dst
);

  mc_state_e state_q, state_d;
  logic      is_load_q, load_set;
  mc_ctrl_t  ctrl;

  mcyc_next #(
    .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_LW(OP_LW),
    .OP_SW(OP_SW), .OP_BEQ(OP_BEQ), .OP_J(OP_J)
  ) u_next (
    .state   (state_q),
    .opcode  (opcode),
    .is_load (is_load_q),
    .nxt     (state_d),
    .load_set(load_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_FETCH;
      is_load_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) is_load_q <= load_set;
    end
  end

  generate
    if (REG_OUT) begin : g_reg_out
      mc_ctrl_t ctrl_d, ctrl_q;
      mcyc_decode u_dec (.state(state_d), .ctrl(ctrl_d));
      always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_FETCH;
        else     ctrl_q <= ctrl_d;
      end
      assign ctrl = ctrl_q;
    end else begin : g_comb_out
      mcyc_decode u_dec (.state(state_q), .ctrl(ctrl));
    end
  endgenerate

  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign addr_sel   = ctrl.addr_sel;
  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign ir_wr      = ctrl.ir_wr;
  assign wb_sel     = ctrl.wb_sel;
  assign pc_src     = ctrl.pc_src;
  assign alu_op     = ctrl.alu_op;
  assign alu_a_sel  = ctrl.alu_a_sel;
  assign alu_b_sel  = ctrl.alu_b_sel;
  assign rf_wr      = ctrl.rf_wr;
  assign rf_dst     = ctrl.rf_dst;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       wb_sel,
  input logic [1:0] pc_src,
  input logic [1:0] alu_op,
  input logic [1:0] alu_b_sel,
  input logic       rf_wr,
  input logic       rf_dst
);

  assert_fetch_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_wr && pc_wr && mem_rd));

  assert_decode_follows_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (alu_b_sel == 2'b11 && !ir_wr && !pc_wr && !mem_rd));

  assert_load_writeback_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (rf_wr && wb_sel && !rf_dst));

  assert_store_returns_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_wr);

  assert_rtype_completes_R6: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b10) |=> (rf_wr && rf_dst && !wb_sel));

  assert_branch_returns_R7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr);

  assert_jump_returns_R8: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b10) |=> ir_wr);

  assert_no_conflict_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}) && $onehot0({pc_wr, pc_wr_cond}));

endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
  .wb_sel(wb_sel), .pc_src(pc_src), .alu_op(alu_op), .alu_b_sel(alu_b_sel),
  .rf_wr(rf_wr), .rf_dst(rf_dst)
);

// File: tb/mcyc_ctrl_bench.sv
module mcyc_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic alu_a_sel, rf_wr, rf_dst;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mcyc_ctrl u_mcyc_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel), .pc_src(pc_src),
    .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_wr(rf_wr), .rf_dst(rf_dst)
  );

  // Word: pc_wr,cond,addr_sel,mem_rd,mem_wr,ir_wr,wb_sel,pc_src[2],alu_op[2],a_sel,b_sel[2],rf_wr,rf_dst
  localparam logic [15:0] W_FETCH  = 16'h9404;
  localparam logic [15:0] W_DECODE = 16'h000C;
  localparam logic [15:0] W_MADDR  = 16'h0018;
  localparam logic [15:0] W_MREAD  = 16'h3000;
  localparam logic [15:0] W_MWB    = 16'h0202;
  localparam logic [15:0] W_MWRITE = 16'h2800;
  localparam logic [15:0] W_REXE   = 16'h0050;
  localparam logic [15:0] W_RWB    = 16'h0003;
  localparam logic [15:0] W_BRANCH = 16'h40B0;
  localparam logic [15:0] W_JUMP   = 16'h8100;

  function automatic logic [15:0] got_word();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
            pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst};
  endfunction

  function automatic int steps_of(logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011: return 4;
      6'b000000: return 4;
      6'b000100: return 3;
      6'b000010: return 3;
      default:   return 2;
    endcase
  endfunction

  function automatic logic [15:0] exp_at(logic [5:0] op, int k);
    if (k == 0) return W_FETCH;
    if (k == 1) return W_DECODE;
    case (op)
      6'b100011: return (k == 2) ? W_MADDR : (k == 3) ? W_MREAD : W_MWB;
      6'b101011: return (k == 2) ? W_MADDR : W_MWRITE;
      6'b000000: return (k == 2) ? W_REXE : W_RWB;
      6'b000100: return W_BRANCH;
      default:   return W_JUMP;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] op, int k);
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    case (op)
      6'b100011: return "R4/R10";
      6'b101011: return "R5/R10";
      6'b000000: return "R6/R10";
      6'b000100: return "R7";
      6'b000010: return "R8";
      default:   return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %04h expected %04h", tag, got, exp);
    end
  endtask

  task automatic next_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", got_word(), W_FETCH);

    // R2..R10: every opcode, full sequence, with the opcode inverted after decode
    for (int op = 0; op < 64; op++) begin
      logic [5:0] o;
      int n;
      o = 6'(op);
      n = steps_of(o);
      opcode = o;
      for (int k = 0; k < n; k++) begin
        if (k >= 2) opcode = ~o;
        check(tag_of(o, k), got_word(), exp_at(o, k));
        if (k == n - 1) begin
          next_step();
          check("R9 return to fetch", got_word(), W_FETCH);
        end else begin
          next_step();
        end
      end
    end

    // R11: conflicting enables never seen across one more load sweep
    opcode = 6'b100011;
    for (int k = 0; k < 5; k++) begin
      check("R11 exclusive strobes",
            {14'd0, (mem_rd & mem_wr), (pc_wr & pc_wr_cond)}, 16'd0);
      next_step();
    end

    // R1: reset in the middle of a load, at the read step
    opcode = 6'b100011;
    next_step();
    next_step();
    next_step();
    check("R1 mid-load read step", got_word(), W_MREAD);
    rst = 1'b1;
    next_step();
    rst = 1'b0;
    check("R1 fetch after mid reset", got_word(), W_FETCH);
    opcode = 6'b000010;
    next_step();
    check("R1 decode after mid reset", got_word(), W_DECODE);
    next_step();
    check("R1 jump after mid reset", got_word(), W_JUMP);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule